// File: doc/BRIEF.md
# Double-Square 128-Point Label Mapper

This block turns a 7-bit symbol label into a pair of 16-level PAM amplitudes for a double-square constellation of 128 points. Three label bits are uncoded and four are protected by an outer code. The mapper runs in three steps. It first builds two 4-bit grid indices from the label with AND, OR and XOR gates. It then rotates the index pair by 45 degrees, using a modulo-16 difference and a modulo-16 sum. Finally it scales each rotated index to an odd amplitude between -15 and +15. The datapath uses no multiplier and no table. Every step is either gate logic or an add or subtract whose width is a power of two.

A label with a valid strobe goes in on every clock. The two amplitudes and their valid flag come out of one register stage, one cycle later. If the strobe is low, the output registers keep their values. The amplitudes are two's complement values that are ready to feed a precoder.

Top module: `dsq_label_mapper`

## Requirements
- R1: The label bit order is `in_label[6]`=u1, `[5]`=u2, `[4]`=u3, `[3]`=c1, `[2]`=c2, `[1]`=c3, `[0]`=c4. The first index p has p[3]=u1&u3, p[2]=u1^u3, p[1]=c1 and p[0]=c1^c2.
- R2: The second index q has q[3]=(u2&u3&~u1)|(u1&u2&~u3), q[2]=u2^u3, q[1]=c3 and q[0]=c3^c4.
- R3: The rotated indices are y1=(p-q) mod 16 and y2=(p+q) mod 16. Because y1+y2 = 2p mod 16, the sum out_amp1+out_amp2+30 is always a multiple of 4.
- R4: Each amplitude is 2*y-15, with out_amp1 taken from y1 and out_amp2 from y2. Every amplitude is odd and lies in -15..+15.
- R5: out_valid equals in_valid from the previous clock edge. The amplitudes of a label accepted at one edge appear right after the next edge.
- R6: During synchronous active-high reset, and in the cycle after it, out_valid is 0 and both amplitudes are 0.
- R7: The 128 labels map to 128 distinct (out_amp1, out_amp2) pairs.
- R8: While in_valid is low, both amplitudes hold their previous values, whatever the label input does.
- R9: Within the coded field, neighbouring grid positions differ in one bit. Changing only c2 moves p by exactly 1. Changing only c4 moves q by exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Label strobe |
| in_label | input | 7 | Label {u1,u2,u3,c1,c2,c3,c4} |
| out_valid | output | 1 | Amplitudes valid |
| out_amp1 | output | AMP_W (5) | First PAM amplitude, signed |
| out_amp2 | output | AMP_W (5) | Second PAM amplitude, signed |

## Verification
A small table of hand-worked labels checks a few cases on their own. These are the all-zero label, the all-one label, a single uncoded bit, a single coded bit on each axis, and two mixed labels. Each one exposes a different gate in the index equations or a different wrap of the modulo-16 rotation. A full sweep of all 128 labels then compares every output with an independent model and records each amplitude pair. This catches any mistake in the equation for q[3] that would map two labels onto the same point. Labels that change while the strobe is low show whether the outputs hold. A reset in the middle of traffic shows whether the output registers clear.

// File: rtl/dsq_map_pkg.sv
package dsq_map_pkg;

    localparam int LABEL_W = 7;
    localparam int IDX_W   = 4;
    localparam int LANES   = 2;
    localparam int SCALE_W = IDX_W + 2;

    typedef struct packed {
        logic u1;
        logic u2;
        logic u3;
        logic c1;
        logic c2;
        logic c3;
        logic c4;
    } dsq_label_t;

    typedef logic [IDX_W-1:0] dsq_idx_t;

    typedef struct packed {
        dsq_idx_t p;
        dsq_idx_t q;
    } dsq_pair_t;

    function automatic dsq_idx_t first_index(input dsq_label_t l);
        dsq_idx_t r;
        r[3] = l.u1 & l.u3;
        r[2] = l.u1 ^ l.u3;
        r[1] = l.c1;
        r[0] = l.c1 ^ l.c2;
        return r;
    endfunction

    function automatic dsq_idx_t second_index(input dsq_label_t l);
        dsq_idx_t r;
        r[3] = (l.u2 & l.u3 & ~l.u1) | (l.u1 & l.u2 & ~l.u3);
        r[2] = l.u2 ^ l.u3;
        r[1] = l.c3;
        r[0] = l.c3 ^ l.c4;
        return r;
    endfunction

    function automatic logic signed [SCALE_W-1:0] scale_odd(input dsq_idx_t y);
        logic signed [SCALE_W-1:0] t;
        t = $signed({1'b0, y, 1'b1}) - $signed(SCALE_W'(16));
        return t;
    endfunction

endpackage

// File: rtl/dsq_index_former.sv
module dsq_index_former
    import dsq_map_pkg::*;
(
    input  dsq_label_t lbl,
    output dsq_pair_t  idx
);
    always_comb begin
        idx.p = first_index(lbl);
        idx.q = second_index(lbl);
    end
endmodule

// File: rtl/dsq_rotator.sv
module dsq_rotator
    import dsq_map_pkg::*;
(
    input  dsq_pair_t x,
    output dsq_pair_t y
);
    // The 45-degree turn: the modulo-16 wrap comes from the index width
    always_comb begin
        y.p = x.p - x.q;
        y.q = x.p + x.q;
    end
endmodule

// File: rtl/dsq_amp_map.sv
module dsq_amp_map
    import dsq_map_pkg::*;
#(
    parameter int AMP_W = 5
) (
    input  dsq_idx_t                 y,
    output logic signed [AMP_W-1:0]  amp
);
    logic signed [SCALE_W-1:0] scaled;

    always_comb begin
        scaled = scale_odd(y);
        amp    = AMP_W'(scaled);
    end
endmodule

// File: rtl/dsq_label_mapper.sv
module dsq_label_mapper
    import dsq_map_pkg::*;
#(
    parameter int AMP_W = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [LABEL_W-1:0]        in_label,
    output logic                      out_valid,
    output logic signed [AMP_W-1:0]   out_amp1,
    output logic signed [AMP_W-1:0]   out_amp2
);
    dsq_label_t lbl;
    dsq_pair_t  grid;
    dsq_pair_t  rot;
    dsq_idx_t   lane_idx [LANES];
    logic signed [AMP_W-1:0] lane_amp [LANES];
    logic signed [AMP_W-1:0] amp_q    [LANES];
    logic       valid_q;

    assign lbl = dsq_label_t'(in_label);

    dsq_index_former u_index (
        .lbl (lbl),
        .idx (grid)
    );

    dsq_rotator u_rot (
        .x (grid),
        .y (rot)
    );

    assign lane_idx[0] = rot.p;
    assign lane_idx[1] = rot.q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dsq_amp_map #(.AMP_W(AMP_W)) u_amp (
            .y   (lane_idx[g]),
            .amp (lane_amp[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                amp_q[g] <= '0;
            end else if (in_valid) begin
                amp_q[g] <= lane_amp[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
        end
    end

    assign out_valid = valid_q;
    assign out_amp1  = amp_q[0];
    assign out_amp2  = amp_q[1];
endmodule

// File: rtl/dsq_map_checker.sv
module dsq_map_checker
    import dsq_map_pkg::*;
#(
    parameter int AMP_W = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic [LABEL_W-1:0]       in_label,
    input logic                     out_valid,
    input logic signed [AMP_W-1:0]  out_amp1,
    input logic signed [AMP_W-1:0]  out_amp2
);
    localparam logic signed [AMP_W-1:0] AMP_MAX = AMP_W'(15);
    localparam logic signed [AMP_W-1:0] AMP_MIN = -AMP_W'(15);

    logic [1:0] sum_low;
    assign sum_low = out_amp1[1:0] + out_amp2[1:0] + 2'b10;

    a_r5_valid_rises: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r5_valid_falls: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_amp1 == '0 && out_amp2 == '0));

    a_r4_amp_odd_in_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_amp1[0] && out_amp2[0]
                       && out_amp1 <= AMP_MAX && out_amp1 >= AMP_MIN
                       && out_amp2 <= AMP_MAX && out_amp2 >= AMP_MIN));

    a_r3_sum_multiple_of_four: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sum_low == 2'b00));

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_amp1) && $stable(out_amp2)));
endmodule

bind dsq_label_mapper dsq_map_checker #(.AMP_W(AMP_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_label  (in_label),
    .out_valid (out_valid),
    .out_amp1  (out_amp1),
    .out_amp2  (out_amp2)
);

// File: tb/test_dsq_label_mapper.sv
module test_dsq_label_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int AMP_W      = 5;
    localparam int N_VEC      = 7;
    localparam int WATCHDOG   = 20000;

    // {label, expected amp1, expected amp2}
    localparam logic [16:0] VEC [N_VEC] = '{
        {7'b0000000, 5'sd0 - 5'sd15, 5'sd0 - 5'sd15},
        {7'b1111111, 5'sd1,          5'sd9},
        {7'b0010000, 5'sd0 - 5'sd15, 5'sd1},
        {7'b0001000, 5'sd0 - 5'sd9,  5'sd0 - 5'sd9},
        {7'b0000011, 5'sd13,         5'sd0 - 5'sd11},
        {7'b0110101, 5'sd9,          5'sd13},
        {7'b1000110, 5'sd0 - 5'sd11, 5'sd1}
    };

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic [6:0] in_label;
    logic out_valid;
    logic signed [AMP_W-1:0] out_amp1;
    logic signed [AMP_W-1:0] out_amp2;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;
    bit seen [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    dsq_label_mapper #(.AMP_W(AMP_W)) i_dsq_label_mapper (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_label  (in_label),
        .out_valid (out_valid),
        .out_amp1  (out_amp1),
        .out_amp2  (out_amp2)
    );

    function automatic int model_amp(input int lab, input bit second);
        bit u1, u2, u3, c1, c2, c3, c4;
        int p, q, y;
        u1 = lab[6]; u2 = lab[5]; u3 = lab[4];
        c1 = lab[3]; c2 = lab[2]; c3 = lab[1]; c4 = lab[0];
        p = 8*int'(u1 & u3) + 4*int'(u1 ^ u3) + 2*int'(c1) + int'(c1 ^ c2);
        q = 8*int'((u2 & u3 & ~u1) | (u1 & u2 & ~u3)) + 4*int'(u2 ^ u3)
            + 2*int'(c3) + int'(c3 ^ c4);
        y = second ? ((p + q) % 16) : ((p - q + 16) % 16);
        return 2*y - 15;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input bit v, input logic [6:0] lab);
        @(negedge clk);
        in_valid = v;
        in_label = lab;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cycles, WATCHDOG);
                report();
            end
        end
    end

    initial begin
        int a1, a2, key;
        rst = 1'b1;
        in_valid = 1'b0;
        in_label = '0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R6: reset state
        check("R6", int'(out_valid), 0);
        check("R6", int'(out_amp1), 0);
        check("R6", int'(out_amp2), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1 R2 R3 R4 R5: hand-worked vectors
        for (int i = 0; i < N_VEC; i++) begin
            drive(1'b1, VEC[i][16:10]);
            check("R5", int'(out_valid), 1);
            check("R1/R2/R3/R4", int'(out_amp1), int'($signed(VEC[i][9:5])));
            check("R1/R2/R3/R4", int'(out_amp2), int'($signed(VEC[i][4:0])));
        end

        // R9: single coded-bit flips move one index by one step
        drive(1'b1, 7'b0000100);
        check("R9", int'(out_amp1), -13);
        check("R9", int'(out_amp2), -13);
        drive(1'b1, 7'b0000001);
        check("R9", int'(out_amp1), -17 + 32);
        check("R9", int'(out_amp2), -13);

        // R7 sweep against model, with distinctness
        for (int i = 0; i < 256; i++) seen[i] = 1'b0;
        for (int lab = 0; lab < 128; lab++) begin
            drive(1'b1, 7'(lab));
            a1 = int'(out_amp1);
            a2 = int'(out_amp2);
            check("R1/R2/R4", a1, model_amp(lab, 1'b0));
            check("R3/R4", a2, model_amp(lab, 1'b1));
            key = ((a1 + 15) / 2) * 16 + ((a2 + 15) / 2);
            if (key < 0 || key > 255) key = 0;
            check("R7", int'(seen[key]), 0);
            seen[key] = 1'b1;
        end

        // R8: idle strobe holds amplitudes while the label changes
        drive(1'b1, 7'b0110101);
        drive(1'b0, 7'b1000110);
        check("R5", int'(out_valid), 0);
        check("R8", int'(out_amp1), 9);
        check("R8", int'(out_amp2), 13);
        drive(1'b0, 7'b0000011);
        check("R8", int'(out_amp1), 9);
        check("R8", int'(out_amp2), 13);

        // R6: reset in the middle of traffic
        drive(1'b1, 7'b1111111);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R6", int'(out_valid), 0);
        check("R6", int'(out_amp1), 0);
        check("R6", int'(out_amp2), 0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check("R6", int'(out_valid), 0);
        check("R6", int'(out_amp1), 0);

        report();
    end
endmodule